// File: doc/BRIEF.md
# Set/Clear Peripheral Register Bank

This block is the register front end of a peripheral that sits on a 32-bit bus and accepts word accesses only. It holds a mode word, a bank of channel-enable bits and an interrupt mask. It turns writes into one-cycle command pulses, and it reads raw status bits from the peripheral logic. Channel enables and interrupt mask bits are never rewritten whole. Each is changed through a pair of write-only addresses: one sets the bits written as one, the other clears them. Software can therefore change a single bit with one store and no read-modify-write.

The block combines the raw status bits, each gated by its mask bit, into a single interrupt-source line for an interrupt controller. Byte and half-word accesses are accepted, but the two low address bits are dropped and the full data word is used. Read data is registered and appears the cycle after the read strobe.

Word offsets (byte address with the low two bits ignored): 0x00 command, 0x04 mode, 0x08 channel set, 0x0C channel clear, 0x10 channel state, 0x14 raw status, 0x18 mask set, 0x1C mask clear, 0x20 mask state.

Top module: `scbank_top`

## Requirements
- R1: After reset, the mode, channel-state and mask registers read zero, `cmdPulse` is zero, `busRdata` is zero and `irqOut` is low.
- R2: A write to offset 0x00 drives `cmdPulse` with the low CMD_W data bits for exactly the one cycle after the write edge. Zero bits give no pulse.
- R3: Offset 0x04 is read/write. Only the low MODE_W bits are stored and driven on `modeOut`, and higher bits read zero.
- R4: A write to offset 0x08 sets each channel-state bit whose data bit is one and leaves the others unchanged. The state is visible on `chanOut` and at offset 0x10.
- R5: A write to offset 0x0C clears each channel-state bit whose data bit is one and leaves the others unchanged.
- R6: Writes to offsets 0x18 and 0x1C set and clear mask bits in the same way, and the mask reads back at offset 0x20.
- R7: `irqOut` is high exactly when some bit of `statIn` is high and its mask bit is set. It follows `statIn` in the same cycle.
- R8: `busSize` (00 byte, 01 half-word, 10 or 11 word) has no effect, and address bits 1:0 are ignored. Every access acts on the whole aligned word with the full data.
- R9: Reads of write-only offsets (0x00, 0x08, 0x0C, 0x18, 0x1C) and of unmapped offsets return zero. Writes to read-only offsets (0x10, 0x14, 0x20) change nothing.
- R10: `busRdata` shows the value selected by a read in the cycle after the read edge. A write in that same cycle is not yet seen. `busRdata` is zero in the cycle after any edge without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | DATA_W | Write data |
| busSize | input | 2 | Access size code |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busRdata | output | DATA_W | Registered read data |
| statIn | input | IRQ_W | Raw status bits from peripheral logic |
| cmdPulse | output | CMD_W | One-cycle command pulses |
| modeOut | output | MODE_W | Mode register contents |
| chanOut | output | CH_W | Channel-state bits |
| irqOut | output | 1 | Masked interrupt source |

## Verification
Two cases are hard to reach from the ports. The first is showing that a write had no effect on state that cannot be seen directly. The bench reaches it by writing to a read-only offset, or by writing zeros to a set or clear offset, and then reading the affected register back through the bus before any other write. The second is the sub-word case. The bench sends byte and half-word accesses with misaligned addresses to the set and mode offsets, and it checks that the full data word landed. A behavioural model tracks every register and is compared each cycle, so each masked status pattern is also checked against `irqOut` while the mask changes under it.

// File: rtl/scbank_pkg.sv
package scbank_pkg;

  // Word indices of the register bank (byte offset / 4)
  localparam int unsigned IDX_CMD    = 0;
  localparam int unsigned IDX_MODE   = 1;
  localparam int unsigned IDX_CHSET  = 2;
  localparam int unsigned IDX_CHCLR  = 3;
  localparam int unsigned IDX_CHSTAT = 4;
  localparam int unsigned IDX_RAW    = 5;
  localparam int unsigned IDX_MSET   = 6;
  localparam int unsigned IDX_MCLR   = 7;
  localparam int unsigned IDX_MASK   = 8;

  typedef enum logic [2:0] {
    RD_ZERO = 3'd0,
    RD_MODE = 3'd1,
    RD_CHAN = 3'd2,
    RD_RAW  = 3'd3,
    RD_MASK = 3'd4
  } rdSel_t;

  typedef struct packed {
    logic   cmdWr;
    logic   modeWr;
    logic   chSet;
    logic   chClr;
    logic   mSet;
    logic   mClr;
    logic   rdEn;
    rdSel_t rdSel;
  } strobe_t;

endpackage

// File: rtl/scbank_ctrl.sv
module scbank_ctrl
  import scbank_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic [IDX_W-1:0] wordIdx,
  input  logic             busWe,
  input  logic             busRe,
  output strobe_t          stb
);

  logic hitCmd, hitMode, hitChSet, hitChClr, hitChStat, hitRaw, hitMSet, hitMClr, hitMask;

  always_comb begin
    hitCmd    = (wordIdx == IDX_W'(IDX_CMD));
    hitMode   = (wordIdx == IDX_W'(IDX_MODE));
    hitChSet  = (wordIdx == IDX_W'(IDX_CHSET));
    hitChClr  = (wordIdx == IDX_W'(IDX_CHCLR));
    hitChStat = (wordIdx == IDX_W'(IDX_CHSTAT));
    hitRaw    = (wordIdx == IDX_W'(IDX_RAW));
    hitMSet   = (wordIdx == IDX_W'(IDX_MSET));
    hitMClr   = (wordIdx == IDX_W'(IDX_MCLR));
    hitMask   = (wordIdx == IDX_W'(IDX_MASK));
  end

  always_comb begin
    stb        = '0;
    stb.cmdWr  = busWe && hitCmd;
    stb.modeWr = busWe && hitMode;
    stb.chSet  = busWe && hitChSet;
    stb.chClr  = busWe && hitChClr;
    stb.mSet   = busWe && hitMSet;
    stb.mClr   = busWe && hitMClr;
    stb.rdEn   = busRe;
    if (hitMode)        stb.rdSel = RD_MODE;
    else if (hitChStat) stb.rdSel = RD_CHAN;
    else if (hitRaw)    stb.rdSel = RD_RAW;
    else if (hitMask)   stb.rdSel = RD_MASK;
    else                stb.rdSel = RD_ZERO;
  end

endmodule

// File: rtl/scbank_setclr.sv
module scbank_setclr #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         setEn,
  input  logic         clrEn,
  input  logic [W-1:0] bits,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  q[i] <= 1'b0;
      else if (clrEn && bits[i])  q[i] <= 1'b0;
      else if (setEn && bits[i])  q[i] <= 1'b1;
    end
  end

endmodule

// File: rtl/scbank_data.sv
module scbank_data
  import scbank_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CMD_W  = 8,
  parameter int unsigned MODE_W = 12,
  parameter int unsigned CH_W   = 16,
  parameter int unsigned IRQ_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IRQ_W-1:0]  statIn,
  output logic [CMD_W-1:0]  cmdPulse,
  output logic [MODE_W-1:0] modeOut,
  output logic [CH_W-1:0]   chanOut,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);

  logic [IRQ_W-1:0]  maskQ;
  logic [DATA_W-1:0] rdNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cmdPulse <= '0;
    else if (stb.cmdWr) cmdPulse <= wrData[CMD_W-1:0];
    else                cmdPulse <= '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           modeOut <= '0;
    else if (stb.modeWr) modeOut <= wrData[MODE_W-1:0];
  end

  scbank_setclr #(.W(CH_W)) u_chan (
    .clk   (clk),
    .rstN  (rstN),
    .setEn (stb.chSet),
    .clrEn (stb.chClr),
    .bits  (wrData[CH_W-1:0]),
    .q     (chanOut)
  );

  scbank_setclr #(.W(IRQ_W)) u_mask (
    .clk   (clk),
    .rstN  (rstN),
    .setEn (stb.mSet),
    .clrEn (stb.mClr),
    .bits  (wrData[IRQ_W-1:0]),
    .q     (maskQ)
  );

  always_comb begin
    case (stb.rdSel)
      RD_MODE: rdNext = DATA_W'(modeOut);
      RD_CHAN: rdNext = DATA_W'(chanOut);
      RD_RAW:  rdNext = DATA_W'(statIn);
      RD_MASK: rdNext = DATA_W'(maskQ);
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         rdData <= '0;
    else if (stb.rdEn) rdData <= rdNext;
    else               rdData <= '0;
  end

  assign irqOut = |(statIn & maskQ);

endmodule

// File: rtl/scbank_top.sv
module scbank_top
  import scbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CMD_W  = 8,
  parameter int unsigned MODE_W = 12,
  parameter int unsigned CH_W   = 16,
  parameter int unsigned IRQ_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [1:0]        busSize,
  input  logic              busWe,
  input  logic              busRe,
  output logic [DATA_W-1:0] busRdata,
  input  logic [IRQ_W-1:0]  statIn,
  output logic [CMD_W-1:0]  cmdPulse,
  output logic [MODE_W-1:0] modeOut,
  output logic [CH_W-1:0]   chanOut,
  output logic              irqOut
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  strobe_t stb;

  scbank_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .wordIdx (busAddr[ADDR_W-1:2]),
    .busWe   (busWe),
    .busRe   (busRe),
    .stb     (stb)
  );

  scbank_data #(
    .DATA_W (DATA_W),
    .CMD_W  (CMD_W),
    .MODE_W (MODE_W),
    .CH_W   (CH_W),
    .IRQ_W  (IRQ_W)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (busWdata),
    .statIn   (statIn),
    .cmdPulse (cmdPulse),
    .modeOut  (modeOut),
    .chanOut  (chanOut),
    .rdData   (busRdata),
    .irqOut   (irqOut)
  );

endmodule

// File: rtl/scbank_checker.sv
module scbank_checker #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CMD_W  = 8,
  parameter int unsigned CH_W   = 16,
  parameter int unsigned IRQ_W  = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [1:0]        busSize,
  input logic              busWe,
  input logic              busRe,
  input logic [DATA_W-1:0] busRdata,
  input logic [IRQ_W-1:0]  statIn,
  input logic [CMD_W-1:0]  cmdPulse,
  input logic [CH_W-1:0]   chanOut,
  input logic              irqOut
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  assign idx = busAddr[ADDR_W-1:2];

  // R2: a pulse only follows a command write
  a_r2_pulse_from_write: assert property (@(posedge clk) disable iff (!rstN)
    (cmdPulse != '0) |-> $past(busWe && idx == IDX_W'(0)));

  // R4: written ones are set next cycle
  a_r4_set_lands: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && idx == IDX_W'(2)) |=>
      ((chanOut & $past(busWdata[CH_W-1:0])) == $past(busWdata[CH_W-1:0])));

  // R5: written ones are cleared next cycle
  a_r5_clr_lands: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && idx == IDX_W'(3)) |=> ((chanOut & $past(busWdata[CH_W-1:0])) == '0));

  // R7: no status, no interrupt
  a_r7_quiet_without_status: assert property (@(posedge clk) disable iff (!rstN)
    (statIn == '0) |-> !irqOut);

  // R8: sub-word set access still acts on the full word
  a_r8_subword_set: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busSize != 2'b10 && busSize != 2'b11 && idx == IDX_W'(2)) |=>
      ((chanOut & $past(busWdata[CH_W-1:0])) == $past(busWdata[CH_W-1:0])));

  // R9: writing the channel-state offset changes nothing
  a_r9_ro_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && idx == IDX_W'(4)) |=> $stable(chanOut));

  // R10: no read, zero read data
  a_r10_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rstN)
    !busRe |=> (busRdata == '0));

endmodule

bind scbank_top scbank_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CMD_W  (CMD_W),
  .CH_W   (CH_W),
  .IRQ_W  (IRQ_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busSize  (busSize),
  .busWe    (busWe),
  .busRe    (busRe),
  .busRdata (busRdata),
  .statIn   (statIn),
  .cmdPulse (cmdPulse),
  .chanOut  (chanOut),
  .irqOut   (irqOut)
);

// File: tb/scbank_top_bench.sv
module scbank_top_bench;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int CMD_W  = 8;
  localparam int MODE_W = 12;
  localparam int CH_W   = 16;
  localparam int IRQ_W  = 10;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [1:0]        busSize = 2'b10;
  logic              busWe = 1'b0;
  logic              busRe = 1'b0;
  logic [DATA_W-1:0] busRdata;
  logic [IRQ_W-1:0]  statIn = '0;
  logic [CMD_W-1:0]  cmdPulse;
  logic [MODE_W-1:0] modeOut;
  logic [CH_W-1:0]   chanOut;
  logic              irqOut;

  int nChecks = 0;
  int nFail = 0;
  bit cmpOn = 0;

  always #4 clk = ~clk;

  scbank_top u_scbank_top (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busSize(busSize), .busWe(busWe), .busRe(busRe), .busRdata(busRdata),
    .statIn(statIn), .cmdPulse(cmdPulse), .modeOut(modeOut),
    .chanOut(chanOut), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // Behavioural reference model
  int unsigned mMode, mChan, mMask, mCmd, mRd;

  function automatic int unsigned peek(input int unsigned word);
    case (word)
      1: return mMode;
      4: return mChan;
      5: return int'(statIn);
      8: return mMask;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int unsigned w;
    int unsigned d;
    w = int'(busAddr) / 4;
    d = busWdata;
    if (!rstN) begin
      mMode = 0; mChan = 0; mMask = 0; mCmd = 0; mRd = 0;
    end else begin
      mRd  = busRe ? peek(w) : 0;
      mCmd = (busWe && w == 0) ? (d & 32'hFF) : 0;
      if (busWe) begin
        case (w)
          1: mMode = d & 32'hFFF;
          2: mChan = mChan | (d & 32'hFFFF);
          3: mChan = mChan & ~d;
          6: mMask = mMask | (d & 32'h3FF);
          7: mMask = mMask & ~d;
          default: ;
        endcase
      end
    end
  end

  always @(posedge clk) begin
    #2;
    if (cmpOn) begin
      chk("R2 model cmdPulse", 32'(cmdPulse), mCmd);
      chk("R3 model modeOut", 32'(modeOut), mMode);
      chk("R4 R5 model chanOut", 32'(chanOut), mChan);
      chk("R10 model busRdata", busRdata, mRd);
      chk("R7 model irqOut", 32'(irqOut), 32'(((int'(statIn) & mMask) != 0)));
    end
  end

  task automatic go(input int a, input logic [31:0] d, input bit we, input bit re,
                    input logic [1:0] sz = 2'b10);
    busAddr = ADDR_W'(a); busWdata = d; busWe = we; busRe = re; busSize = sz;
    @(negedge clk);
    busWe = 1'b0; busRe = 1'b0; busSize = 2'b10;
  endtask

  task automatic rd(input int a, input logic [1:0] sz = 2'b10);
    go(a, 32'h0, 1'b0, 1'b1, sz);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cmdPulse in reset", 32'(cmdPulse), 0);
    chk("R1 irqOut in reset", 32'(irqOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    cmpOn = 1;
    rd('h04); chk("R1 mode reset", busRdata, 0);
    rd('h10); chk("R1 chan reset", busRdata, 0);
    rd('h20); chk("R1 mask reset", busRdata, 0);

    // R2 command pulses
    go('h00, 32'hFFFF_FFA5, 1, 0); chk("R2 pulse", 32'(cmdPulse), 32'hA5);
    @(negedge clk);                chk("R2 pulse ends", 32'(cmdPulse), 0);
    go('h00, 32'h0, 1, 0);         chk("R2 zero write", 32'(cmdPulse), 0);
    rd('h00);                      chk("R9 read command", busRdata, 0);

    // R3 mode
    go('h04, 32'hFFFF_FFFF, 1, 0);
    rd('h04); chk("R3 mode width", busRdata, 32'hFFF);
    go('h04, 32'h0000_0123, 1, 0);
    rd('h04); chk("R3 mode value", busRdata, 32'h123);

    // R4 / R5 channel set and clear
    go('h08, 32'h00F0, 1, 0);
    go('h08, 32'h0003, 1, 0);
    rd('h10); chk("R4 set accumulates", busRdata, 32'h00F3);
    go('h08, 32'h0, 1, 0);
    rd('h10); chk("R4 zero set", busRdata, 32'h00F3);
    go('h0C, 32'h0030, 1, 0);
    rd('h10); chk("R5 clear", busRdata, 32'h00C3);
    go('h0C, 32'h0, 1, 0);
    rd('h10); chk("R5 zero clear", busRdata, 32'h00C3);
    rd('h08); chk("R9 read set offset", busRdata, 0);

    // R9 writes to read-only offsets
    go('h10, 32'hFFFF_FFFF, 1, 0);
    rd('h10); chk("R9 chan state write", busRdata, 32'h00C3);
    go('h20, 32'hFFFF_FFFF, 1, 0);
    rd('h20); chk("R9 mask state write", busRdata, 0);
    rd('h3C); chk("R9 unmapped read", busRdata, 0);

    // R6 / R7 mask and interrupt
    statIn = 10'h005;
    go('h18, 32'h0004, 1, 0);
    chk("R7 masked status", 32'(irqOut), 1);
    rd('h20); chk("R6 mask set", busRdata, 32'h004);
    rd('h14); chk("R9 raw status read", busRdata, 32'h005);
    statIn = 10'h001;
    #1 chk("R7 unmasked status", 32'(irqOut), 0);
    @(negedge clk);
    go('h18, 32'h0201, 1, 0);
    chk("R7 second mask", 32'(irqOut), 1);
    go('h1C, 32'h0001, 1, 0);
    chk("R7 after mask clear", 32'(irqOut), 0);
    rd('h1C); chk("R9 read clear offset", busRdata, 0);
    rd('h20); chk("R6 mask clear", busRdata, 32'h204);
    statIn = 10'h200;
    #1 chk("R7 top bit", 32'(irqOut), 1);
    @(negedge clk);

    // R8 sub-word accesses
    go('h0B, 32'h0000_0100, 1, 0, 2'b00);
    rd('h12, 2'b01); chk("R8 byte set", busRdata, 32'h01C3);
    go('h06, 32'h0000_0ABC, 1, 0, 2'b01);
    rd('h05, 2'b00); chk("R8 half mode", busRdata, 32'hABC);

    // R10 read and write in the same cycle
    go('h04, 32'h0000_0055, 1, 1);
    chk("R10 read sees old value", busRdata, 32'hABC);
    @(negedge clk);
    chk("R10 idle zero", busRdata, 0);
    rd('h04); chk("R10 new value", busRdata, 32'h055);

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule